// File: doc/BRIEF.md
# Read-after-write stall interlock

This unit sits beside the decode stage of a five-stage in-order pipeline: fetch, decode, execute, memory, writeback. It looks at the instruction being decoded and at the three older instructions held in the execute, memory and writeback pipeline registers. When a register that the decoding instruction reads will be written by one of those older instructions, it asserts a hold. The hold freezes the program counter and the fetch/decode register. On the same cycle it asserts a bubble request, which loads a noop into the decode/execute register. There are no forwarding paths. The comparison is repeated every cycle, so the stalled instruction leaves decode on the first cycle in which nothing matches.

Each downstream stage presents its opcode and two raw 3-bit fields: the regB field and the low destination field (instruction bits 0-2). The unit chooses the written register from these by opcode. The decoding instruction presents its opcode and its regA and regB fields. A build parameter, `CHECK_WB`, sets whether the writeback stage takes part in the comparison. It should be cleared only when the register file returns a value written in the same cycle to a read in that cycle.

Opcode codes (3 bits): add=0, nor=1, lw=2, sw=3, beq=4, reserved=5, halt=6, noop=7.

Top module: `raw_interlock`

## Requirements
- R1: When the decoding opcode is add(0), nor(1), lw(2), sw(3) or beq(4), its regA field is a source. A match between regA and the register written by any compared downstream stage asserts the stall.
- R2: The regB field is a source only for add(0), nor(1), sw(3) and beq(4). For a decoding lw(2), a regB value equal to a downstream destination causes no stall.
- R3: A downstream add(0) or nor(1) writes the register named by its destination field (bits 0-2). A downstream lw(2) writes the register named by its regB field.
- R4: A downstream stage holding sw(3), beq(4), reserved(5), halt(6) or noop(7) writes nothing and never causes a stall, whatever its fields hold.
- R5: A decoding halt(6), noop(7) or reserved(5) reads no register and never stalls.
- R6: The hold output and the bubble output are always equal. Both follow the inputs combinationally, within the same cycle.
- R7: With `CHECK_WB`=1, the execute, memory and writeback stages are all compared. With `CHECK_WB`=0, the writeback stage is ignored.
- R8: In a pipeline driven by the interlock, an add directly followed by a nor that reads the add's result spends three stall cycles in decode with `CHECK_WB`=1, and two with `CHECK_WB`=0, before a normal decode.
- R9: A sw whose regA reads the register that the immediately preceding lw loads stalls three cycles (`CHECK_WB`=1) or two (`CHECK_WB`=0). A consumer placed two instructions behind its producer stalls one cycle fewer than an adjacent one. A lw following a lw whose destination equals the second lw's regB field does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op_i | input | 3 | Opcode of the instruction in decode |
| dec_ra_i | input | REG_W | regA field of the instruction in decode |
| dec_rb_i | input | REG_W | regB field of the instruction in decode |
| ex_op_i | input | 3 | Opcode held in decode/execute register |
| ex_rb_i | input | REG_W | regB field held in decode/execute register |
| ex_rd_i | input | REG_W | Destination field held in decode/execute register |
| mem_op_i | input | 3 | Opcode held in execute/memory register |
| mem_rb_i | input | REG_W | regB field held in execute/memory register |
| mem_rd_i | input | REG_W | Destination field held in execute/memory register |
| wb_op_i | input | 3 | Opcode held in memory/writeback register |
| wb_rb_i | input | REG_W | regB field held in memory/writeback register |
| wb_rd_i | input | REG_W | Destination field held in memory/writeback register |
| stall_hold_o | output | 1 | Freeze program counter and fetch/decode register |
| inject_bubble_o | output | 1 | Load a noop into the decode/execute register |

## Verification
The hardest case to reach from the ports is the stall length in cycles: a stall decision feeds back into the contents of the downstream stages. A single combinational vector cannot show that the stall ends on exactly the right cycle. The bench therefore wraps both parameter variants in a small pipeline model of its own. This model holds on stall, inserts noops and advances otherwise. The bench runs short programs through it and counts the decode stall cycles of each instruction. A near-exhaustive sweep covers the single-cycle decision: every decode opcode, source pair and downstream opcode, placed in each stage, with field values that either collide with or miss the sources. A pseudo-random pass then fills all three stages at once.

// File: rtl/rawi_pkg.sv
package rawi_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_RSV  = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } op_e;

    // Spec-level helpers, used by the assertions only.
    function automatic logic op_writes(op_e op);
        return (op == OP_ADD) || (op == OP_NOR) || (op == OP_LW);
    endfunction

    function automatic logic op_quiet(op_e op);
        return (op == OP_HALT) || (op == OP_NOOP) || (op == OP_RSV);
    endfunction

endpackage

// File: rtl/rawi_dest_sel.sv
module rawi_dest_sel
    import rawi_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  op_e              op_i,
    input  logic [REG_W-1:0] rb_i,
    input  logic [REG_W-1:0] rd_i,
    output logic             wr_en_o,
    output logic [REG_W-1:0] wr_reg_o
);

    always_comb begin
        wr_en_o  = 1'b0;
        wr_reg_o = rd_i;
        unique case (op_i)
            OP_ADD, OP_NOR: begin
                wr_en_o  = 1'b1;
                wr_reg_o = rd_i;
            end
            OP_LW: begin
                wr_en_o  = 1'b1;
                wr_reg_o = rb_i;
            end
            default: begin
                wr_en_o  = 1'b0;
                wr_reg_o = rd_i;
            end
        endcase
    end

    // R3: load destination comes from the regB field
    always_comb begin
        a_r3_load_dest: assert (!(op_i == OP_LW) || (wr_en_o && wr_reg_o == rb_i))
            else $error("lw destination not taken from regB field");
        a_r4_no_write: assert (op_writes(op_i) || !wr_en_o)
            else $error("non-writing opcode flagged as writer");
    end

endmodule

// File: rtl/rawi_src_sel.sv
module rawi_src_sel
    import rawi_pkg::*;
(
    input  op_e  op_i,
    output logic use_a_o,
    output logic use_b_o
);

    always_comb begin
        use_a_o = 1'b0;
        use_b_o = 1'b0;
        unique case (op_i)
            OP_ADD, OP_NOR, OP_SW, OP_BEQ: begin
                use_a_o = 1'b1;
                use_b_o = 1'b1;
            end
            OP_LW: begin
                use_a_o = 1'b1;
                use_b_o = 1'b0;
            end
            default: begin
                use_a_o = 1'b0;
                use_b_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rawi_cmp.sv
module rawi_cmp #(
    parameter int REG_W = 3
) (
    input  logic             live_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_reg_i,
    input  logic             use_a_i,
    input  logic             use_b_i,
    input  logic [REG_W-1:0] ra_i,
    input  logic [REG_W-1:0] rb_i,
    output logic             hit_a_o,
    output logic             hit_b_o
);

    logic armed;

    always_comb begin
        armed   = live_i && wr_en_i;
        hit_a_o = armed && use_a_i && (wr_reg_i == ra_i);
        hit_b_o = armed && use_b_i && (wr_reg_i == rb_i);
    end

endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
    import rawi_pkg::*;
#(
    parameter int REG_W    = 3,
    parameter bit CHECK_WB = 1'b1
) (
    input  logic [OP_W-1:0]  dec_op_i,
    input  logic [REG_W-1:0] dec_ra_i,
    input  logic [REG_W-1:0] dec_rb_i,
    input  logic [OP_W-1:0]  ex_op_i,
    input  logic [REG_W-1:0] ex_rb_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic [OP_W-1:0]  mem_op_i,
    input  logic [REG_W-1:0] mem_rb_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic [OP_W-1:0]  wb_op_i,
    input  logic [REG_W-1:0] wb_rb_i,
    input  logic [REG_W-1:0] wb_rd_i,
    output logic             stall_hold_o,
    output logic             inject_bubble_o
);

    localparam int NSTG  = 3;
    localparam int NLIVE = CHECK_WB ? 3 : 2;

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rd;
    } slot_t;

    typedef struct packed {
        logic            stall;
        logic [NSTG-1:0] hits;
    } verdict_t;

    slot_t            slot    [NSTG];
    op_e              dec_op;
    logic             use_a, use_b;
    logic [NSTG-1:0]  wr_en, hit_a, hit_b;
    logic [REG_W-1:0] wr_reg  [NSTG];
    verdict_t         verdict_d;

    assign dec_op  = op_e'(dec_op_i);
    assign slot[0] = '{op: op_e'(ex_op_i),  rb: ex_rb_i,  rd: ex_rd_i};
    assign slot[1] = '{op: op_e'(mem_op_i), rb: mem_rb_i, rd: mem_rd_i};
    assign slot[2] = '{op: op_e'(wb_op_i),  rb: wb_rb_i,  rd: wb_rd_i};

    rawi_src_sel u_src (
        .op_i    (dec_op),
        .use_a_o (use_a),
        .use_b_o (use_b)
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        rawi_dest_sel #(.REG_W(REG_W)) u_dst (
            .op_i     (slot[g].op),
            .rb_i     (slot[g].rb),
            .rd_i     (slot[g].rd),
            .wr_en_o  (wr_en[g]),
            .wr_reg_o (wr_reg[g])
        );
        rawi_cmp #(.REG_W(REG_W)) u_cmp (
            .live_i   (g < NLIVE),
            .wr_en_i  (wr_en[g]),
            .wr_reg_i (wr_reg[g]),
            .use_a_i  (use_a),
            .use_b_i  (use_b),
            .ra_i     (dec_ra_i),
            .rb_i     (dec_rb_i),
            .hit_a_o  (hit_a[g]),
            .hit_b_o  (hit_b[g])
        );
    end

    always_comb begin
        verdict_d.hits  = hit_a | hit_b;
        verdict_d.stall = |verdict_d.hits;
    end

    assign stall_hold_o    = verdict_d.stall;
    assign inject_bubble_o = verdict_d.stall;

    // ---------------- assertions ----------------
    logic any_live_writer;
    logic lw_cause_seen;
    logic early_writer;

    always_comb begin
        any_live_writer = 1'b0;
        lw_cause_seen   = 1'b0;
        for (int s = 0; s < NLIVE; s++) begin
            if (op_writes(slot[s].op)) any_live_writer = 1'b1;
            if (wr_en[s] && wr_reg[s] == dec_ra_i) lw_cause_seen = 1'b1;
        end
        early_writer = op_writes(slot[0].op) || op_writes(slot[1].op);

        // R5: idle decode never stalls
        a_r5_quiet_decode: assert (!(op_quiet(dec_op) && stall_hold_o))
            else $error("stall raised for an instruction with no sources");
        // R4: stall requires a writing instruction in a compared stage
        a_r4_needs_writer: assert (any_live_writer || !stall_hold_o)
            else $error("stall raised with no writer downstream");
        // R7: writeback stage alone cannot stall when excluded
        a_r7_wb_ignored: assert (CHECK_WB || early_writer || !stall_hold_o)
            else $error("excluded writeback stage caused a stall");
        // R2: a decoding lw stalls only on its regA field
        a_r2_lw_rega_only: assert (!(dec_op == OP_LW && stall_hold_o) || lw_cause_seen)
            else $error("lw stalled without a regA match");
        // R6: both control outputs agree
        a_r6_outputs_agree: assert (stall_hold_o == inject_bubble_o)
            else $error("hold and bubble disagree");
    end

endmodule

// File: tb/raw_interlock_tb.sv
`timescale 1ns/100ps
module raw_interlock_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0] d_op, d_ra, d_rb;
    logic [2:0] s_op [3];
    logic [2:0] s_rb [3];
    logic [2:0] s_rd [3];
    logic hold_a, bub_a, hold_b, bub_b;

    raw_interlock #(.REG_W(3), .CHECK_WB(1'b1)) u_dut (
        .dec_op_i(d_op), .dec_ra_i(d_ra), .dec_rb_i(d_rb),
        .ex_op_i(s_op[0]), .ex_rb_i(s_rb[0]), .ex_rd_i(s_rd[0]),
        .mem_op_i(s_op[1]), .mem_rb_i(s_rb[1]), .mem_rd_i(s_rd[1]),
        .wb_op_i(s_op[2]), .wb_rb_i(s_rb[2]), .wb_rd_i(s_rd[2]),
        .stall_hold_o(hold_a), .inject_bubble_o(bub_a)
    );

    raw_interlock #(.REG_W(3), .CHECK_WB(1'b0)) u_dut_nowb (
        .dec_op_i(d_op), .dec_ra_i(d_ra), .dec_rb_i(d_rb),
        .ex_op_i(s_op[0]), .ex_rb_i(s_rb[0]), .ex_rd_i(s_rd[0]),
        .mem_op_i(s_op[1]), .mem_rb_i(s_rb[1]), .mem_rd_i(s_rd[1]),
        .wb_op_i(s_op[2]), .wb_rb_i(s_rb[2]), .wb_rd_i(s_rd[2]),
        .stall_hold_o(hold_b), .inject_bubble_o(bub_b)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Spec model of the single-cycle decision
    function automatic bit exp_stall(bit wb);
        bit st = 0;
        bit ua = (d_op <= 3'd4);
        bit ub = (d_op == 3'd0) || (d_op == 3'd1) || (d_op == 3'd3) || (d_op == 3'd4);
        for (int s = 0; s < (wb ? 3 : 2); s++) begin
            if (s_op[s] <= 3'd2) begin
                logic [2:0] dst = (s_op[s] == 3'd2) ? s_rb[s] : s_rd[s];
                if ((ua && dst == d_ra) || (ub && dst == d_rb)) st = 1;
            end
        end
        return st;
    endfunction

    function automatic string tag_for(int s);
        if (d_op >= 3'd5) return "R5";
        if (s_op[s] >= 3'd3) return "R4";
        if (s == 2) return "R7";
        if (s_op[s] == 3'd2) return "R3";
        if (d_op == 3'd2) return "R2";
        return "R1";
    endfunction

    task automatic compare_both(input string tag);
        bit ea = exp_stall(1'b1);
        bit eb = exp_stall(1'b0);
        chk(hold_a == ea, tag, "hold wb_on", hold_a, ea);
        chk(hold_b == eb, tag, "hold wb_off", hold_b, eb);
        chk(bub_a == hold_a && bub_b == hold_b, "R6", "bubble==hold", bub_a, hold_a);
    endtask

    task automatic clear_stages();
        for (int s = 0; s < 3; s++) begin
            s_op[s] = 3'd7; s_rb[s] = 3'd0; s_rd[s] = 3'd0;
        end
    endtask

    // ---------------- pipeline model ----------------
    logic [2:0] pg_op [5];
    logic [2:0] pg_ra [5];
    logic [2:0] pg_rb [5];
    logic [2:0] pg_rd [5];

    task automatic set_ins(input int i, input logic [2:0] op, input logic [2:0] ra,
                           input logic [2:0] rb, input logic [2:0] rd);
        pg_op[i] = op; pg_ra[i] = ra; pg_rb[i] = rb; pg_rd[i] = rd;
    endtask

    task automatic run_prog(input bit wb, input int n, input int exp_st[5], input string tag);
        logic [2:0] p_op [4];
        logic [2:0] p_ra [4];
        logic [2:0] p_rb [4];
        logic [2:0] p_rd [4];
        int p_ix [4];
        int cnt [5];
        int pc = 1;
        for (int i = 0; i < 5; i++) cnt[i] = 0;
        for (int k = 0; k < 4; k++) begin
            p_op[k] = 3'd7; p_ra[k] = 0; p_rb[k] = 0; p_rd[k] = 0; p_ix[k] = -1;
        end
        p_op[0] = pg_op[0]; p_ra[0] = pg_ra[0]; p_rb[0] = pg_rb[0]; p_rd[0] = pg_rd[0]; p_ix[0] = 0;
        for (int cyc = 0; cyc < 18; cyc++) begin
            bit st;
            @(negedge clk);
            d_op = p_op[0]; d_ra = p_ra[0]; d_rb = p_rb[0];
            for (int s = 0; s < 3; s++) begin
                s_op[s] = p_op[s+1]; s_rb[s] = p_rb[s+1]; s_rd[s] = p_rd[s+1];
            end
            #1;
            st = wb ? hold_a : hold_b;
            if ((wb ? bub_a : bub_b) != st)
                chk(1'b0, "R6", "bubble vs hold in pipeline", 0, 1);
            for (int k = 3; k >= 2; k--) begin
                p_op[k] = p_op[k-1]; p_ra[k] = p_ra[k-1];
                p_rb[k] = p_rb[k-1]; p_rd[k] = p_rd[k-1]; p_ix[k] = p_ix[k-1];
            end
            if (st) begin
                if (p_ix[0] >= 0) cnt[p_ix[0]]++;
                p_op[1] = 3'd7; p_ix[1] = -1;
            end else begin
                p_op[1] = p_op[0]; p_ra[1] = p_ra[0];
                p_rb[1] = p_rb[0]; p_rd[1] = p_rd[0]; p_ix[1] = p_ix[0];
                if (pc < n) begin
                    p_op[0] = pg_op[pc]; p_ra[0] = pg_ra[pc];
                    p_rb[0] = pg_rb[pc]; p_rd[0] = pg_rd[pc]; p_ix[0] = pc;
                    pc++;
                end else begin
                    p_op[0] = 3'd7; p_ix[0] = -1;
                end
            end
        end
        for (int i = 0; i < n; i++)
            chk(cnt[i] == exp_st[i], tag, $sformatf("stall cycles of instr %0d wb=%0d", i, wb),
                cnt[i], exp_st[i]);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int lfsr = 32'h1234_5677;
        d_op = 3'd7; d_ra = 0; d_rb = 0;
        clear_stages();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R4 / R5: empty pipeline, idle decode: no stall
        chk(!hold_a && !bub_a && !hold_b && !bub_b, "R5", "idle state stall", hold_a, 0);

        // Sweep one occupied stage at a time
        for (int s = 0; s < 3; s++)
            for (int dop = 0; dop < 8; dop++)
                for (int sop = 0; sop < 8; sop++)
                    for (int ra = 0; ra < 8; ra++)
                        for (int rb = 0; rb < 8; rb++)
                            for (int k = 0; k < 4; k++) begin
                                clear_stages();
                                d_op = 3'(dop); d_ra = 3'(ra); d_rb = 3'(rb);
                                s_op[s] = 3'(sop);
                                case (k)
                                    0: begin s_rb[s] = 3'(ra);     s_rd[s] = 3'(ra + 1); end
                                    1: begin s_rb[s] = 3'(rb + 1); s_rd[s] = 3'(rb);     end
                                    2: begin s_rb[s] = 3'(rb);     s_rd[s] = 3'(ra);     end
                                    default: begin s_rb[s] = 3'(ra + 3); s_rd[s] = 3'(ra + 5); end
                                endcase
                                #1;
                                compare_both(tag_for(s));
                            end

        // All three stages busy at once
        for (int it = 0; it < 3000; it++) begin
            lfsr = lfsr * 1103515245 + 12345;
            d_op = lfsr[30:28]; d_ra = lfsr[27:25]; d_rb = lfsr[24:22];
            s_op[0] = lfsr[21:19]; s_rb[0] = lfsr[18:16]; s_rd[0] = lfsr[15:13];
            s_op[1] = lfsr[12:10]; s_rb[1] = lfsr[9:7];   s_rd[1] = lfsr[6:4];
            lfsr = lfsr * 1103515245 + 12345;
            s_op[2] = lfsr[30:28]; s_rb[2] = lfsr[27:25]; s_rd[2] = lfsr[24:22];
            #1;
            compare_both("R1");
        end

        // R8: add 1 2 3 ; nor 3 4 5
        set_ins(0, 3'd0, 3'd1, 3'd2, 3'd3);
        set_ins(1, 3'd1, 3'd3, 3'd4, 3'd5);
        run_prog(1'b1, 2, '{0, 3, 0, 0, 0}, "R8");
        run_prog(1'b0, 2, '{0, 2, 0, 0, 0}, "R8");

        // R9: add 1 2 3; nor 3 4 5; add 6 3 7; lw 3 6 10; sw 6 2 12
        set_ins(2, 3'd0, 3'd6, 3'd3, 3'd7);
        set_ins(3, 3'd2, 3'd3, 3'd6, 3'd2);
        set_ins(4, 3'd3, 3'd6, 3'd2, 3'd4);
        run_prog(1'b0, 5, '{0, 2, 0, 0, 2}, "R9");
        run_prog(1'b1, 5, '{0, 3, 0, 0, 3}, "R9");

        // R9: consumer two behind: add 1 2 3; add 4 4 6; nor 3 3 7
        set_ins(0, 3'd0, 3'd1, 3'd2, 3'd3);
        set_ins(1, 3'd0, 3'd4, 3'd4, 3'd6);
        set_ins(2, 3'd1, 3'd3, 3'd3, 3'd7);
        run_prog(1'b1, 3, '{0, 0, 2, 0, 0}, "R9");
        run_prog(1'b0, 3, '{0, 0, 1, 0, 0}, "R9");

        // R2 / R9: lw 1 5 0; lw 3 5 0 (second lw regB is not a source)
        set_ins(0, 3'd2, 3'd1, 3'd5, 3'd0);
        set_ins(1, 3'd2, 3'd3, 3'd5, 3'd0);
        run_prog(1'b1, 2, '{0, 0, 0, 0, 0}, "R2");

        // R3 / R9: lw 1 4 0; add 4 4 2 (load destination from regB)
        set_ins(0, 3'd2, 3'd1, 3'd4, 3'd0);
        set_ins(1, 3'd0, 3'd4, 3'd4, 3'd2);
        run_prog(1'b1, 2, '{0, 3, 0, 0, 0}, "R3");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule